// File: doc/BRIEF.md
# PWM Period Averaging Filter

This block estimates the mean load current of a switching converter over exactly one PWM ripple period. The converter's ADC delivers a fixed number of samples per PWM period, evenly spaced and locked to the carrier. The block keeps a running sum over the most recent full period of samples. Because the window length matches the switching period, every harmonic of the switching frequency cancels. The sample positions do not need to line up with the carrier peaks, since a full-period mean does not depend on the ripple phase.

A control loop pulses a refresh strobe once or twice per PWM period, at the instants where it updates its modulation index. On each strobe the block captures the current average into its output register. The output then holds that value until the next strobe. A second mode replaces the full-period window with the mean of the two most recent samples. This suits a converter that samples only at the two carrier vertexes of each period. The equivalent delay of the window mode is half a PWM period.

Top module: `pwm_period_avg`

## Requirements
- R1: While rst_ni is low, and after it is released until the first refresh strobe, avg_o is 0 and avg_valid_o is 0.
- R2: With pair_mode_i = 0, a refresh strobe loads avg_o with the sum of the last OVS accepted samples divided by OVS and rounded toward zero. Slots not yet filled since reset count as zero.
- R3: With pair_mode_i = 0, a refresh strobe sets avg_valid_o to 1 only if at least OVS samples have been accepted since reset. Otherwise it sets avg_valid_o to 0.
- R4: When refresh_i is low, avg_o and avg_valid_o keep their values, even when new samples arrive.
- R5: With pair_mode_i = 1, a refresh strobe loads avg_o with the sum of the two most recent accepted samples divided by 2 and rounded toward zero.
- R6: With pair_mode_i = 1, a refresh strobe sets avg_valid_o to 1 only if at least 2 samples have been accepted since reset.
- R7: A value on sample_i is accepted only in a cycle where sample_valid_i is 1. Otherwise it has no effect on the window.
- R8: When a sample and a refresh strobe arrive in the same cycle, the captured average covers only the samples accepted in earlier cycles.
- R9: A sample stream that repeats every OVS samples, with a ripple that sums to zero over one period, gives the DC mean at every strobe, whatever the starting phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | DATA_W | Signed current sample |
| sample_valid_i | input | 1 | sample_i carries a new sample |
| refresh_i | input | 1 | Index-refresh strobe; captures the average |
| pair_mode_i | input | 1 | 0: full-period window; 1: mean of last two samples |
| avg_o | output | DATA_W | Signed averaged current |
| avg_valid_o | output | 1 | avg_o is based on a complete window |

## Verification
The bench builds the block with DATA_W = 12 and OVS = 8. With these values, a sequence of a few dozen samples wraps the circular buffer twice. That same sequence reaches both ends of the signed sample range, -2048 and 2047, so the running sum is exercised at its extremes. An OVS of 8 also gives non-integer means in both signs, which tests rounding toward zero for positive and negative sums. A mid-run reset shows the fill count starting over, seen through the valid flag in both modes.

// File: rtl/pwm_avg_pkg.sv
package pwm_avg_pkg;
  typedef enum logic {
    AVG_WINDOW = 1'b0,
    AVG_PAIR   = 1'b1
  } avg_mode_e;
endpackage

// File: rtl/pwm_avg_ring.sv
// Circular sample store with running window sum and the latest-pair sum.
module pwm_avg_ring #(
  parameter int DATA_W = 12,
  parameter int OVS    = 8,
  localparam int PTR_W = (OVS > 1) ? $clog2(OVS) : 1,
  localparam int SUM_W = DATA_W + $clog2(OVS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_i,
  input  logic signed [DATA_W-1:0] din_i,
  output logic signed [SUM_W-1:0]  win_sum_o,
  output logic signed [DATA_W:0]   pair_sum_o
);
  logic signed [DATA_W-1:0] mem_q [OVS];
  logic [PTR_W-1:0]         ptr_q;
  logic signed [SUM_W-1:0]  sum_q;
  logic signed [DATA_W-1:0] last_q, prev_q;
  logic signed [DATA_W-1:0] oldest;

  assign oldest = mem_q[ptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < OVS; i++) mem_q[i] <= '0;
      ptr_q  <= '0;
      sum_q  <= '0;
      last_q <= '0;
      prev_q <= '0;
    end else if (wr_i) begin
      mem_q[ptr_q] <= din_i;
      ptr_q  <= (ptr_q == PTR_W'(OVS - 1)) ? '0 : ptr_q + 1'b1;
      sum_q  <= sum_q + SUM_W'(din_i) - SUM_W'(oldest);
      prev_q <= last_q;
      last_q <= din_i;
    end
  end

  assign win_sum_o  = sum_q;
  assign pair_sum_o = (DATA_W + 1)'(last_q) + (DATA_W + 1)'(prev_q);
endmodule

// File: rtl/pwm_avg_fill.sv
// Saturating count of accepted samples since reset.
module pwm_avg_fill #(
  parameter int OVS    = 8,
  localparam int CNT_W = $clog2(OVS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  output logic win_full_o,
  output logic pair_full_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (wr_i && cnt_q != CNT_W'(OVS)) cnt_q <= cnt_q + 1'b1;
  end

  assign win_full_o  = (cnt_q == CNT_W'(OVS));
  assign pair_full_o = (cnt_q >= CNT_W'(2));
endmodule

// File: rtl/pwm_avg_scale.sv
// Signed divide by 2**SHIFT, rounded toward zero.
module pwm_avg_scale #(
  parameter int IN_W  = 15,
  parameter int SHIFT = 3
) (
  input  logic signed [IN_W-1:0]       in_i,
  output logic signed [IN_W-SHIFT-1:0] out_o
);
  logic signed [IN_W-1:0] bias, biased;

  assign bias   = in_i[IN_W-1] ? {{(IN_W-SHIFT){1'b0}}, {SHIFT{1'b1}}} : '0;
  assign biased = in_i + bias;
  assign out_o  = biased[IN_W-1:SHIFT];
endmodule

// File: rtl/pwm_period_avg.sv
module pwm_period_avg
  import pwm_avg_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int OVS    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              sample_valid_i,
  input  logic              refresh_i,
  input  logic              pair_mode_i,
  output logic [DATA_W-1:0] avg_o,
  output logic              avg_valid_o
);
  localparam int SH    = $clog2(OVS);
  localparam int SUM_W = DATA_W + SH;

  generate
    if ((1 << SH) != OVS || OVS < 2) begin : g_bad_ovs
      $error("OVS must be a power of two, at least 2");
    end
  endgenerate

  logic signed [SUM_W-1:0]  win_sum;
  logic signed [DATA_W:0]   pair_sum;
  logic signed [DATA_W-1:0] win_avg, pair_avg;
  logic                     win_full, pair_full;
  logic signed [DATA_W-1:0] avg_q;
  logic                     valid_q;
  avg_mode_e                mode;

  assign mode = avg_mode_e'(pair_mode_i);

  pwm_avg_ring #(.DATA_W(DATA_W), .OVS(OVS)) u_ring (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (sample_valid_i),
    .din_i      ($signed(sample_i)),
    .win_sum_o  (win_sum),
    .pair_sum_o (pair_sum)
  );

  pwm_avg_fill #(.OVS(OVS)) u_fill (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (sample_valid_i),
    .win_full_o  (win_full),
    .pair_full_o (pair_full)
  );

  pwm_avg_scale #(.IN_W(SUM_W), .SHIFT(SH)) u_win_scale (
    .in_i  (win_sum),
    .out_o (win_avg)
  );

  pwm_avg_scale #(.IN_W(DATA_W + 1), .SHIFT(1)) u_pair_scale (
    .in_i  (pair_sum),
    .out_o (pair_avg)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      avg_q   <= '0;
      valid_q <= 1'b0;
    end else if (refresh_i) begin
      if (mode == AVG_PAIR) begin
        avg_q   <= pair_avg;
        valid_q <= pair_full;
      end else begin
        avg_q   <= win_avg;
        valid_q <= win_full;
      end
    end
  end

  assign avg_o       = avg_q;
  assign avg_valid_o = valid_q;
endmodule

// File: rtl/pwm_period_avg_chk.sv
module pwm_period_avg_chk #(
  parameter int DATA_W = 12,
  parameter int OVS    = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] sample_i,
  input logic              sample_valid_i,
  input logic              refresh_i,
  input logic              pair_mode_i,
  input logic [DATA_W-1:0] avg_o,
  input logic              avg_valid_o
);
  localparam int CW = $clog2(OVS + 1);

  logic [CW-1:0]            seen_q;
  logic signed [DATA_W-1:0] s0_q, s1_q;
  logic signed [DATA_W:0]   two_sum;
  logic signed [DATA_W-1:0] exp_pair;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= '0;
      s0_q   <= '0;
      s1_q   <= '0;
    end else if (sample_valid_i) begin
      if (seen_q != CW'(OVS)) seen_q <= seen_q + 1'b1;
      s1_q <= s0_q;
      s0_q <= $signed(sample_i);
    end
  end

  assign two_sum  = (DATA_W + 1)'(s0_q) + (DATA_W + 1)'(s1_q);
  assign exp_pair = DATA_W'(two_sum / 2);

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !refresh_i |=> $stable(avg_o) && $stable(avg_valid_o));

  assert_win_not_full_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_i && !pair_mode_i && seen_q != CW'(OVS) |=> !avg_valid_o);

  assert_win_full_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_i && !pair_mode_i && seen_q == CW'(OVS) |=> avg_valid_o);

  assert_pair_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_i && pair_mode_i |=> avg_valid_o == ($past(seen_q) >= CW'(2)));

  assert_pair_value_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_i && pair_mode_i |=> avg_o == $past(exp_pair));

  assert_valid_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(avg_valid_o) |-> $past(refresh_i));
endmodule

bind pwm_period_avg pwm_period_avg_chk #(.DATA_W(DATA_W), .OVS(OVS)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sample_i       (sample_i),
  .sample_valid_i (sample_valid_i),
  .refresh_i      (refresh_i),
  .pair_mode_i    (pair_mode_i),
  .avg_o          (avg_o),
  .avg_valid_o    (avg_valid_o)
);

// File: tb/pwm_period_avg_test.sv
`timescale 1ns/1ps
module pwm_period_avg_test;
  localparam int DATA_W = 12;
  localparam int OVS    = 8;
  localparam int NVEC   = 16;

  // sample, expected avg after strobe, expected valid (window mode, OVS = 8)
  localparam int VEC [NVEC][3] = '{
    '{10, 1, 0}, '{20, 3, 0}, '{30, 7, 0}, '{40, 12, 0},
    '{50, 18, 0}, '{60, 26, 0}, '{70, 35, 0}, '{80, 45, 1},
    '{-100, 31, 1}, '{-200, 3, 1}, '{-300, -37, 1}, '{-5, -43, 1},
    '{7, -48, 1}, '{0, -56, 1}, '{2047, 191, 1}, '{-2048, -74, 1}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [DATA_W-1:0] sample = '0;
  logic              sample_valid = 1'b0;
  logic              refresh = 1'b0;
  logic              pair_mode = 1'b0;
  logic [DATA_W-1:0] avg;
  logic              avg_valid;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  pwm_period_avg #(.DATA_W(DATA_W), .OVS(OVS)) uut (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .sample_i       (sample),
    .sample_valid_i (sample_valid),
    .refresh_i      (refresh),
    .pair_mode_i    (pair_mode),
    .avg_o          (avg),
    .avg_valid_o    (avg_valid)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic chk_out(input string req, input int e_avg, input int e_val);
    chk(req, int'($signed(avg)), e_avg);
    chk(req, int'(avg_valid), e_val);
  endtask

  task automatic push(input int v);
    @(negedge clk);
    sample = DATA_W'(v);
    sample_valid = 1'b1;
    @(negedge clk);
    sample_valid = 1'b0;
    sample = '0;
  endtask

  task automatic strobe();
    @(negedge clk);
    refresh = 1'b1;
    @(negedge clk);
    refresh = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1: held in reset, then released without strobes
    #5;
    chk_out("R1", 0, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    push(500);
    chk_out("R1", 0, 0);
    do_reset();

    // R2 / R3: table walk in window mode
    for (int i = 0; i < NVEC; i++) begin
      push(VEC[i][0]);
      strobe();
      chk_out(VEC[i][2] != 0 ? "R2" : "R3", VEC[i][1], VEC[i][2]);
    end

    // R4: new samples without strobe leave output alone
    for (int i = 0; i < OVS; i++) push(100);
    chk_out("R4", -74, 1);
    strobe();
    chk_out("R2", 100, 1);

    // R7: data without valid is ignored
    @(negedge clk);
    sample = DATA_W'(999);
    repeat (4) @(negedge clk);
    sample = '0;
    strobe();
    chk_out("R7", 100, 1);

    // R8: sample and strobe in same cycle
    @(negedge clk);
    sample = DATA_W'(900);
    sample_valid = 1'b1;
    refresh = 1'b1;
    @(negedge clk);
    sample_valid = 1'b0;
    refresh = 1'b0;
    chk_out("R8", 100, 1);
    strobe();
    chk_out("R8", 200, 1);

    // R9: zero-sum ripple around 50, starting mid-period
    begin
      int rip [8] = '{30, 10, -10, -30, -30, -10, 10, 30};
      for (int k = 0; k < OVS; k++) push(50 + rip[(k + 3) % 8]);
      strobe();
      chk_out("R9", 50, 1);
      for (int k = 0; k < 3; k++) begin
        push(50 + rip[(k + 3) % 8]);
        strobe();
        chk_out("R9", 50, 1);
      end
    end

    // R5: pair mode, rounding toward zero both signs
    pair_mode = 1'b1;
    push(7);
    push(-4);
    strobe();
    chk_out("R5", 1, 1);
    push(-9);
    strobe();
    chk_out("R5", -6, 1);
    push(-1);
    strobe();
    chk_out("R5", -5, 1);

    // R6 / R3: fill count after mid-run reset
    do_reset();
    chk_out("R1", 0, 0);
    push(20);
    strobe();
    chk_out("R6", 10, 0);
    push(30);
    strobe();
    chk_out("R6", 25, 1);
    pair_mode = 1'b0;
    strobe();
    chk_out("R3", 6, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule